// File: doc/BRIEF.md
# Video-Loss Failover Switch Controller

This controller watches a stream of 8-bit level samples taken from an incoming video line. It decides whether that external picture is present or whether a local picture source has to take over the output. A sample that is strobed valid and lies strictly above a programmable threshold counts as evidence of live video. Such a sample hands the output back to the external source at once: the local sync generator is disabled and the output switch is opened.

The takeover runs on a free-running watchdog. A prescaler divides the clock into ticks, and a tick counter raises an expiry once a full window of ticks has gone by. Every detected sample clears both counters. Quiet samples, and samples not strobed valid, leave the counters alone. When the window runs out, the controller enables local sync generation and closes the switch, so that local video reaches the output. The behaviour is deliberately asymmetric: giving control back to the external source takes one sample, while taking control over needs a whole silent window. With the default settings the window is 65536 clock cycles, which is about 3.3 ms, or roughly fifty lines, at a 20 MHz clock.

Top module: `vidloss_failover`

## Requirements
- R1: While reset is applied, and after its release until the first expiry, `sync_en_o` and `switch_close_o` are both 0 (external video passes).
- R2: A sample is a detection only when `sample_valid_i` is 1 and `sample_i` is strictly greater than `THRESHOLD` (default 20). A valid sample equal to the threshold is not a detection.
- R3: A detection sampled at rising edge k drives both outputs to 0 after rising edge k+1, from either mode.
- R4: A detection sampled at edge k restarts the timeout window. No expiry follows from any earlier part of the window.
- R5: If a detection is sampled at edge k and none follows, both outputs stay 0 through edge k+T+1 and become 1 after edge k+T+2, where T = `PRESCALE` × `TIMEOUT_TICKS` clock cycles.
- R6: Samples at or below the threshold, and any sample with `sample_valid_i` at 0, change neither the outputs nor the timing of the next expiry.
- R7: `sync_en_o` and `switch_close_o` are equal at every clock edge.
- R8: Once the outputs are 1, they stay 1 for as long as no detection arrives, including across later wraps of the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| sample_i | input | 8 | Converted video level sample |
| sample_valid_i | input | 1 | Qualifies `sample_i` for one cycle |
| sync_en_o | output | 1 | 1 enables the local sync and picture generator |
| switch_close_o | output | 1 | 1 closes the switch that passes local video to the output |

## Verification
A counter that was not cleared, or that was cleared by a quiet sample, moves the takeover edge away from exactly T+2 cycles after the last detection. The directed tests therefore check both sides of that edge: 0 one cycle before it and 1 on it. A threshold compare off by one, or a detection path that ignores the valid strobe, shows up within two cycles as an output that drops, or within one window as an expiry that comes early or late. A mode register that fails to hold is caught within a few windows of quiet samples, when an output falls back to 0 with no detection to account for it.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

  // Output ownership: external video passes, or local generator drives.
  typedef enum logic {
    FO_PASSIVE = 1'b0,
    FO_LOCAL   = 1'b1
  } fo_mode_e;

endpackage

// File: rtl/vlf_reset_sync.sv
module vlf_reset_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/vlf_level_detect.sv
module vlf_level_detect #(
  parameter int SAMPLE_W  = 8,
  parameter int THRESHOLD = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                valid_i,
  output logic                hit_o
);

  localparam logic [SAMPLE_W-1:0] TH_VAL = SAMPLE_W'(THRESHOLD);

  logic hit_d;
  logic hit_q;

  // Strictly-above compare, qualified by the valid strobe.
  always_comb begin
    hit_d = valid_i && (sample_i > TH_VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit_o = hit_q;

  // R2: a valid sample at or below the threshold never registers a hit.
  p_quiet_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (sample_i <= TH_VAL)) |=> !hit_o);

  // R6: an unqualified sample never registers a hit.
  p_invalid_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !hit_o);

endmodule

// File: rtl/vlf_tick_gen.sv
module vlf_tick_gen #(
  parameter int PRESCALE = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);

  localparam int            PRE_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             wrap;

  always_comb begin
    wrap  = (pre_q == PRE_LAST);
    pre_d = pre_q;
    if (clear_i) begin
      pre_d = '0;
    end else if (wrap) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign tick_o = wrap && !clear_i;

  // R4: a clear restarts the prescaler from zero.
  p_clear_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pre_q == '0));

  // R5: ticks are spaced by the prescale ratio, never back to back.
  p_tick_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

endmodule

// File: rtl/vlf_watchdog.sv
module vlf_watchdog #(
  parameter int TIMEOUT_TICKS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic expire_o
);

  localparam int              WD_W    = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(TIMEOUT_TICKS - 1);

  logic [WD_W-1:0] wd_q;
  logic [WD_W-1:0] wd_d;
  logic            exp_q;
  logic            exp_d;
  logic            at_last;

  always_comb begin
    at_last = (wd_q == WD_LAST);
    wd_d    = wd_q;
    exp_d   = 1'b0;
    if (clear_i) begin
      wd_d  = '0;
    end else if (tick_i) begin
      // Free-running: wrap after the last tick and flag an expiry.
      if (at_last) begin
        wd_d  = '0;
        exp_d = 1'b1;
      end else begin
        wd_d  = wd_q + WD_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q  <= '0;
      exp_q <= 1'b0;
    end else begin
      wd_q  <= wd_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;

  // R5: the tick counter never leaves its window.
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_q <= WD_LAST);

  // R4: a clear empties the window and suppresses any pending expiry.
  p_clear_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> ((wd_q == '0) && !expire_o));

endmodule

// File: rtl/vlf_mode_fsm.sv
module vlf_mode_fsm
  import vlf_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_i,
  input  logic     expire_i,
  output fo_mode_e mode_o
);

  fo_mode_e mode_q;
  fo_mode_e mode_d;

  // A detection outranks a simultaneous expiry.
  always_comb begin
    mode_d = mode_q;
    if (hit_i) begin
      mode_d = FO_PASSIVE;
    end else if (expire_i) begin
      mode_d = FO_LOCAL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= FO_PASSIVE;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

  // R3: a detection hands the output back to the external source.
  p_hit_releases_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> (mode_o == FO_PASSIVE));

  // R5: an expiry with no detection hands the output to the local source.
  p_expiry_takes_over_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !hit_i) |=> (mode_o == FO_LOCAL));

  // R8: local ownership persists until a detection arrives.
  p_hold_local_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == FO_LOCAL) && !hit_i) |=> (mode_o == FO_LOCAL));

endmodule

// File: rtl/vidloss_failover.sv
module vidloss_failover
  import vlf_pkg::*;
#(
  parameter int SAMPLE_W      = 8,
  parameter int THRESHOLD     = 20,
  parameter int PRESCALE      = 256,
  parameter int TIMEOUT_TICKS = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  output logic                sync_en_o,
  output logic                switch_close_o
);

  logic     rst_sync_n;
  logic     hit;
  logic     tick;
  logic     expire;
  fo_mode_e mode;

  vlf_reset_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  vlf_level_detect #(
    .SAMPLE_W  (SAMPLE_W),
    .THRESHOLD (THRESHOLD)
  ) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .sample_i (sample_i),
    .valid_i  (sample_valid_i),
    .hit_o    (hit)
  );

  vlf_tick_gen #(
    .PRESCALE (PRESCALE)
  ) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .clear_i (hit),
    .tick_o  (tick)
  );

  vlf_watchdog #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_wdog (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .clear_i  (hit),
    .tick_i   (tick),
    .expire_o (expire)
  );

  vlf_mode_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .hit_i    (hit),
    .expire_i (expire),
    .mode_o   (mode)
  );

  assign sync_en_o      = (mode == FO_LOCAL);
  assign switch_close_o = (mode == FO_LOCAL);

  // R7: generator enable and switch control move together.
  p_outputs_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_en_o == switch_close_o);

  // R1: both outputs are low while the internal reset holds.
  p_reset_state_r1: assert property (@(posedge clk_i)
    !rst_sync_n |-> (!sync_en_o && !switch_close_o));

endmodule

// File: tb/tb_vidloss_failover.sv
`timescale 1ns/1ps
module tb_vidloss_failover;

  localparam int P  = 4;
  localparam int N  = 16;
  localparam int T  = P * N;
  localparam int TH = 20;

  logic       clk;
  logic       rst_n;
  logic [7:0] sample;
  logic       valid;
  logic       sync_en;
  logic       sw_close;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vidloss_failover #(
    .SAMPLE_W(8), .THRESHOLD(TH), .PRESCALE(P), .TIMEOUT_TICKS(N)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(valid),
    .sync_en_o(sync_en), .switch_close_o(sw_close)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Checks both outputs shortly after the edge just passed.
  task automatic expect_out(input logic exp, input string req);
    #2;
    checks++;
    if (sync_en !== exp || sw_close !== exp) begin
      errors++;
      $display("FAIL %s: sync_en=%0b switch_close=%0b expected %0b", req, sync_en, sw_close, exp);
    end
  endtask

  // Drives one sample and returns just after the edge that captures it.
  task automatic hit_at(input logic [7:0] v);
    @(negedge clk); sample = v; valid = 1'b1;
    @(posedge clk);
  endtask

  task automatic idle(input int n, input logic [7:0] v, input logic vld);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample = v; valid = vld;
      @(posedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sample = '0; valid = 1'b0;
    repeat (4) @(posedge clk);
    expect_out(1'b0, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    expect_out(1'b0, "R1 after release");
    idle(T / 2, 8'd0, 1'b0);
    expect_out(1'b0, "R1 before first expiry");
  endtask

  task automatic t_timeout();
    hit_at(8'd200);
    idle(1, 8'd0, 1'b0);
    expect_out(1'b0, "R3 passive after hit");
    idle(T, 8'd0, 1'b0);
    expect_out(1'b0, "R5 not before T+2");
    idle(1, 8'd0, 1'b0);
    expect_out(1'b1, "R5 takeover at T+2");
  endtask

  task automatic t_leave_and_threshold();
    hit_at(8'd21);
    expect_out(1'b1, "R3 still local at k");
    idle(1, 8'd20, 1'b1);
    expect_out(1'b0, "R3 released at k+1");
    idle(T, 8'(TH), 1'b1);
    expect_out(1'b0, "R2 equal-threshold not before T+2");
    idle(1, 8'(TH), 1'b1);
    expect_out(1'b1, "R2 R6 equal-threshold ignored, takeover at T+2");
  endtask

  task automatic t_invalid_ignored();
    idle(5, 8'd255, 1'b0);
    expect_out(1'b1, "R6 invalid strobe ignored");
  endtask

  task automatic t_stay_local();
    idle(3 * T, 8'd10, 1'b1);
    expect_out(1'b1, "R8 held across wraps");
  endtask

  task automatic t_restart();
    hit_at(8'd90);
    idle(1, 8'd0, 1'b0);
    expect_out(1'b0, "R3 release before restart");
    idle(T / 2, 8'd0, 1'b0);
    hit_at(8'd90);
    idle(T / 2, 8'd0, 1'b0);
    expect_out(1'b0, "R4 first window abandoned");
    idle(T / 2 + 1, 8'd5, 1'b1);
    expect_out(1'b0, "R4 restarted window not before T+2");
    idle(1, 8'd5, 1'b1);
    expect_out(1'b1, "R4 restarted window expires at T+2");
  endtask

  task automatic t_agree();
    checks++;
    if (sync_en !== sw_close) begin
      errors++;
      $display("FAIL R7: sync_en=%0b switch_close=%0b expected equal", sync_en, sw_close);
    end
  endtask

  initial begin
    t_reset();
    t_timeout();
    t_agree();
    t_leave_and_threshold();
    t_invalid_ignored();
    t_stay_local();
    t_restart();
    t_agree();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule